// File: doc/BRIEF.md
# Byte SPI Master with Selectable Clock Phase, Sample Point and Bit Rate

This block is the master side of a serial peripheral link, one byte at a time. Software hands it a byte through a simple write strobe, and the transfer begins on the next clock with no separate start command. Eight bits leave on the serial output, most significant first, while eight bits are gathered from the serial input. When the last bit is taken, the gathered byte is placed in the read buffer and an interrupt flag goes high.

Three configuration inputs shape the waveform. One sets the level the serial clock rests at. One chooses whether data changes as the clock leaves its resting level or as it returns to it. One chooses whether the input is captured halfway through each bit window or at its end. A three-bit rate code picks the bit rate. The choices are three fixed fractions of the system clock, half the rate of an external tick, and a divisor taken from an 8-bit reload value. Status outputs report busy, buffer full, write collision and receive overflow. The serial output can be turned off for receive-only use.

Each bit occupies two half periods. With 8-bit data, a transfer is sixteen half periods long, numbered 0 to 15. Bit k is driven during halves 2k and 2k+1.

Top module: `spi_byte_master`

## Requirements
- R1: A write strobe while idle starts a transfer. `busy` is high from the next clock through the clock edge that ends half 15. A transfer lasts 16 half periods.
- R2: Bits are sent most significant first. Bit k of the transfer is on `sdo` during halves 2k and 2k+1. With `cfg_early_out` at 1, bit 7 is on `sdo` before the first clock edge.
- R3: While idle, `sck` equals `cfg_cpol`, and this includes the state after reset.
- R4: The active clock level is the inverse of `cfg_cpol`. With `cfg_early_out` at 1 the clock is active in odd halves, so data changes on the return to idle. With `cfg_early_out` at 0 the clock is active in even halves, so data changes as the clock goes active.
- R5: With `cfg_smp_late` at 0, `sdi` is captured at the end of half 2k, the middle of the window. With `cfg_smp_late` at 1, it is captured at the end of half 2k+1. The first captured bit becomes the most significant bit.
- R6: Each value of `cfg_rate` gives a half-period length:

  | `cfg_rate` | Half-period length |
  |---|---|
  | 0 | 2 clocks |
  | 1 | 8 clocks |
  | 2 | 32 clocks |
  | 3 | one `tmr_tick` pulse |
  | 4 | 2·(`cfg_reload`+1) clocks |
  | 5 to 7 | 2 clocks |
- R7: On the cycle `busy` falls, `irq` is 1 and the received byte is on `rdata` with `buf_full` set.
- R8: With `cfg_sdo_en` at 0, `sdo` and `sdo_oe` stay 0. Reception still fills the buffer normally.
- R9: A read strobe clears `buf_full`.
- R10: A write while busy sets `wcol`. The written byte is dropped and the running transfer continues unchanged.
- R11: If a transfer ends while `buf_full` is set and no read is made in that cycle, `rovf` is set. `rdata` and `buf_full` are kept.
- R12: `flag_clr` clears `irq`, `wcol` and `rovf`. A flag that is set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wdata | input | 8 | Byte to send |
| rd_en | input | 1 | Read strobe, clears buffer full |
| flag_clr | input | 1 | Clears irq, wcol and rovf |
| cfg_cpol | input | 1 | Idle level of sck |
| cfg_early_out | input | 1 | 1: data changes on return to idle |
| cfg_smp_late | input | 1 | 1: sample at end of bit window |
| cfg_rate | input | 3 | Bit-rate select |
| cfg_reload | input | 8 | Reload divisor value |
| cfg_sdo_en | input | 1 | Serial output enable |
| tmr_tick | input | 1 | External timer tick pulse |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| rdata | output | 8 | Receive buffer |
| busy | output | 1 | Transfer in progress |
| buf_full | output | 1 | Unread byte in buffer |
| irq | output | 1 | Transfer complete flag |
| wcol | output | 1 | Write collision flag |
| rovf | output | 1 | Receive overflow flag |

## Verification
The hardest cases to reach are the ones that depend on exact timing: the capture point, and events inside a running transfer. The bench drives `sdi` with a value that changes every half period, not every bit, so a byte captured mid-window differs from one captured at the window end. A reference model tracks the half-period index, and the bench drives `sdi` from that index one falling edge ahead of each capture. A write is injected partway through a transfer to exercise the collision case. Two transfers are then chained without a read, so that the second one completes onto a full buffer.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int W  = 8,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wdata,
  input  logic          rd_en,
  input  logic          flag_clr,
  input  logic          cfg_cpol,
  input  logic          cfg_early_out,
  input  logic          cfg_smp_late,
  input  logic [2:0]    cfg_rate,
  input  logic [RW-1:0] cfg_reload,
  input  logic          cfg_sdo_en,
  input  logic          tmr_tick,
  input  logic          sdi,
  output logic          sck,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [W-1:0]  rdata,
  output logic          busy,
  output logic          buf_full,
  output logic          irq,
  output logic          wcol,
  output logic          rovf
);
  localparam int HW = $clog2(2 * W);
  localparam int CW = RW + 2;
  localparam logic [HW-1:0] LAST = HW'(2 * W - 1);

  logic [HW-1:0] half;
  logic [CW-1:0] div_cnt, half_len;
  logic [W-1:0]  shreg;
  logic          mid_bit, tick, in_bit;

  always_comb begin
    case (cfg_rate)
      3'd1:    half_len = CW'(8);
      3'd2:    half_len = CW'(32);
      3'd4:    half_len = ({2'b00, cfg_reload} + CW'(1)) << 1;
      default: half_len = CW'(2);
    endcase
  end

  assign tick   = busy & ((cfg_rate == 3'd3) ? tmr_tick : (div_cnt == half_len - CW'(1)));
  assign in_bit = cfg_smp_late ? sdi : mid_bit;
  assign sck    = cfg_cpol ^ (busy & (half[0] ~^ cfg_early_out));
  assign sdo    = cfg_sdo_en & shreg[W-1];
  assign sdo_oe = cfg_sdo_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      half     <= '0;
      div_cnt  <= '0;
      shreg    <= '0;
      mid_bit  <= 1'b0;
      rdata    <= '0;
      buf_full <= 1'b0;
      irq      <= 1'b0;
      wcol     <= 1'b0;
      rovf     <= 1'b0;
    end else begin
      if (flag_clr) begin
        irq  <= 1'b0;
        wcol <= 1'b0;
        rovf <= 1'b0;
      end
      if (rd_en) buf_full <= 1'b0;
      if (wr_en) begin
        if (busy) wcol <= 1'b1;
        else begin
          busy    <= 1'b1;
          shreg   <= wdata;
          half    <= '0;
          div_cnt <= '0;
        end
      end
      if (tick) begin
        div_cnt <= '0;
        half    <= half + HW'(1);
        if (!half[0]) mid_bit <= sdi;
        else          shreg   <= {shreg[W-2:0], in_bit};
        if (half == LAST) begin
          busy <= 1'b0;
          irq  <= 1'b1;
          if (buf_full && !rd_en) rovf <= 1'b1;
          else begin
            rdata    <= {shreg[W-2:0], in_bit};
            buf_full <= 1'b1;
          end
        end
      end else if (busy) begin
        div_cnt <= div_cnt + CW'(1);
      end
    end
  end
endmodule

module spi_byte_master_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         rd_en,
  input logic         flag_clr,
  input logic         cfg_cpol,
  input logic         sck,
  input logic         sdo,
  input logic         sdo_oe,
  input logic [W-1:0] rdata,
  input logic         busy,
  input logic         buf_full,
  input logic         irq,
  input logic         wcol,
  input logic         rovf
);
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy) |=> busy);
  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cfg_cpol));
  assert_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (irq && buf_full));
  assert_sdo_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);
  assert_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy) |=> !buf_full);
  assert_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> wcol);
  assert_no_overwrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rovf) |-> ($stable(rdata) && buf_full));
  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !busy && !wr_en) |=> (!irq && !wcol && !rovf));
endmodule

bind spi_byte_master spi_byte_master_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .flag_clr(flag_clr),
  .cfg_cpol(cfg_cpol), .sck(sck), .sdo(sdo), .sdo_oe(sdo_oe), .rdata(rdata),
  .busy(busy), .buf_full(buf_full), .irq(irq), .wcol(wcol), .rovf(rovf)
);

// File: tb/spi_byte_master_test.sv
module spi_byte_master_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, flag_clr = 0;
  logic [7:0] wdata = '0, cfg_reload = '0;
  logic cfg_cpol = 0, cfg_early_out = 0, cfg_smp_late = 0, cfg_sdo_en = 1;
  logic [2:0] cfg_rate = '0;
  logic tmr_tick = 0, sdi = 0;
  logic sck, sdo, sdo_oe, busy, buf_full, irq, wcol, rovf;
  logic [7:0] rdata;

  spi_byte_master uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .flag_clr(flag_clr), .cfg_cpol(cfg_cpol), .cfg_early_out(cfg_early_out),
    .cfg_smp_late(cfg_smp_late), .cfg_rate(cfg_rate), .cfg_reload(cfg_reload),
    .cfg_sdo_en(cfg_sdo_en), .tmr_tick(tmr_tick), .sdi(sdi), .sck(sck), .sdo(sdo),
    .sdo_oe(sdo_oe), .rdata(rdata), .busy(busy), .buf_full(buf_full), .irq(irq),
    .wcol(wcol), .rovf(rovf)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, tc = 0;
  logic [15:0] pat = '0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int hlen();
    case (cfg_rate)
      3'd1: return 8;
      3'd2: return 32;
      3'd4: return 2 * (int'(cfg_reload) + 1);
      default: return 2;
    endcase
  endfunction

  function automatic logic [7:0] exp_rx(input logic [15:0] p, input logic late);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = late ? p[14-2*i] : p[15-2*i];
    return r;
  endfunction

  int m_half = 0, m_sub = 0;
  bit m_busy = 0, m_irq = 0, m_wcol = 0, m_rovf = 0, m_full = 0;
  logic [7:0] m_buf = '0, m_tx = '0;

  always @(posedge clk) begin
    bit fin, full_pre, tk;
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_irq = 0; m_wcol = 0; m_rovf = 0; m_full = 0; m_buf = '0;
      m_half = 0; m_sub = 0;
    end else begin
      fin = 0; full_pre = m_full; tk = 0;
      if (m_busy) begin
        tk = (cfg_rate == 3'd3) ? tmr_tick : (m_sub + 1 == hlen());
        if (tk) begin
          m_sub = 0;
          if (m_half == 15) fin = 1;
          m_half++;
        end else m_sub++;
      end
      if (flag_clr) begin m_irq = 0; m_wcol = 0; m_rovf = 0; end
      if (rd_en) m_full = 0;
      if (wr_en) begin
        if (m_busy) m_wcol = 1;
        else begin m_busy = 1; m_half = 0; m_sub = 0; m_tx = wdata; end
      end
      if (fin) begin
        m_busy = 0; m_irq = 1;
        if (full_pre && !rd_en) m_rovf = 1;
        else begin m_buf = exp_rx(pat, cfg_smp_late); m_full = 1; end
      end
      #(CLK_P/4);
      chk("R1 busy", 16'(busy), 16'(m_busy));
      chk("R3/R4 sck", 16'(sck),
          16'(cfg_cpol ^ (m_busy && (((m_half % 2) == 1) == cfg_early_out))));
      if (m_busy) chk("R2/R8 sdo", 16'(sdo), 16'(cfg_sdo_en ? m_tx[7 - m_half/2] : 1'b0));
      chk("R8 sdo_oe", 16'(sdo_oe), 16'(cfg_sdo_en));
      chk("R7/R11 rdata", 16'(rdata), 16'(m_buf));
      chk("R7/R9 buf_full", 16'(buf_full), 16'(m_full));
      chk("R7/R12 irq", 16'(irq), 16'(m_irq));
      chk("R10 wcol", 16'(wcol), 16'(m_wcol));
      chk("R11 rovf", 16'(rovf), 16'(m_rovf));
    end
  end

  always @(negedge clk) begin
    tc++;
    tmr_tick <= (tc % 3 == 0);
    sdi <= (m_busy && m_half < 16) ? pat[15 - m_half] : 1'b0;
  end

  task automatic cfg(input logic pol, input logic early, input logic late,
                     input logic [2:0] rate, input logic [7:0] rl, input logic en);
    @(negedge clk);
    cfg_cpol = pol; cfg_early_out = early; cfg_smp_late = late;
    cfg_rate = rate; cfg_reload = rl; cfg_sdo_en = en;
  endtask

  task automatic xfer(input logic [7:0] d, input logic [15:0] p, input int exp_len,
                      input bit collide);
    int n;
    @(negedge clk);
    pat = p; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; n = 0;
    while (busy) begin
      n++;
      if (collide && n == 6) begin wdata = 8'hFF; wr_en = 1; end
      else wr_en = 0;
      @(negedge clk);
    end
    wr_en = 0;
    if (exp_len > 0) chk("R1/R6 length", 16'(n), 16'(exp_len));
  endtask

  task automatic pulse_rd_clr();
    @(negedge clk); rd_en = 1; flag_clr = 1;
    @(negedge clk); rd_en = 0; flag_clr = 0;
    @(negedge clk);
    chk("R9 full cleared", 16'(buf_full), 16'd0);
    chk("R12 flags cleared", 16'({irq, wcol, rovf}), 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R3 reset sck", 16'(sck), 16'(cfg_cpol));
    chk("R7 reset rdata", 16'(rdata), 16'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset busy", 16'(busy), 16'd0);

    cfg(0, 0, 0, 3'd0, 8'd0, 1);
    xfer(8'hA5, 16'hC3A5, 32, 0);
    chk("R5 mid sample", 16'(rdata), 16'(exp_rx(16'hC3A5, 0)));
    chk("R7 irq", 16'(irq), 16'd1);
    pulse_rd_clr();

    cfg(1, 1, 1, 3'd1, 8'd0, 1);
    xfer(8'h3C, 16'h5A0F, 128, 0);
    chk("R5 late sample", 16'(rdata), 16'(exp_rx(16'h5A0F, 1)));
    pulse_rd_clr();

    cfg(0, 1, 0, 3'd2, 8'd0, 1);
    xfer(8'h81, 16'hF00D, 512, 0);
    pulse_rd_clr();

    cfg(1, 0, 1, 3'd4, 8'd3, 1);
    xfer(8'h96, 16'h1234, 128, 0);
    chk("R6 reload rx", 16'(rdata), 16'(exp_rx(16'h1234, 1)));
    pulse_rd_clr();
    cfg(0, 0, 1, 3'd4, 8'd0, 1);
    xfer(8'h69, 16'hBEEF, 32, 0);
    pulse_rd_clr();

    cfg(0, 1, 0, 3'd3, 8'd0, 1);
    xfer(8'hC7, 16'hA55A, 0, 0);
    chk("R6 timer rx", 16'(rdata), 16'(exp_rx(16'hA55A, 0)));
    pulse_rd_clr();

    cfg(1, 1, 0, 3'd6, 8'd9, 1);
    xfer(8'h0F, 16'h7E81, 32, 0);
    pulse_rd_clr();

    cfg(0, 0, 0, 3'd0, 8'd0, 0);
    xfer(8'hFF, 16'h9C63, 32, 0);
    chk("R8 receive only", 16'(rdata), 16'(exp_rx(16'h9C63, 0)));
    pulse_rd_clr();

    cfg(0, 1, 1, 3'd1, 8'd0, 1);
    xfer(8'h52, 16'h0FF0, 128, 1);
    chk("R10 wcol set", 16'(wcol), 16'd1);
    chk("R10 rx intact", 16'(rdata), 16'(exp_rx(16'h0FF0, 1)));
    pulse_rd_clr();

    cfg(0, 0, 0, 3'd0, 8'd0, 1);
    xfer(8'h11, 16'h3333, 32, 0);
    xfer(8'h22, 16'hCCCC, 32, 0);
    chk("R11 rovf", 16'(rovf), 16'd1);
    chk("R11 kept", 16'(rdata), 16'(exp_rx(16'h3333, 0)));
    chk("R11 full", 16'(buf_full), 16'd1);
    pulse_rd_clr();

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; errors++;
    $display("FAIL R1 watchdog actual %0d expected below 150000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule